// File: doc/BRIEF.md
# Macropixel Sparsified Periphery Readout

This block sits at the edge of a binary pixel matrix that is cut into 4x4 macropixels. Each macropixel has two private wires to the block: a hit line, which is high while any of its sixteen pixel latches holds a hit, and an enable line. When a hit line is seen, the block marks that macropixel as pending and stores the timestamp present on its timestamp input at that edge.

Pending macropixels are served one at a time. The block raises the enable of the chosen macropixel together with one of four shared column-enable lines, and reads that column's four rows back over four shared data lines. The matrix clears a column's latches when the column is read. The block keeps only set pixels and emits one word per hit pixel on a valid/ready output. Each word carries the macropixel index, the pixel position and the stored timestamp. The matrix size is a parameter, and the default is 32 columns by 128 rows.

Top module: `mp_sparse_readout`

## Requirements
- R1: A macropixel whose hit line is high at a clock edge while it is not pending becomes pending at that edge, and its timestamp is the value of ts_in at that edge.
- R2: A pending macropixel keeps its stored timestamp until its read ends, even if new hits arrive in it before then.
- R3: When idle, the block picks the pending macropixel with the lowest index. A read in progress is not preempted by a lower-index macropixel that becomes pending.
- R4: A read drives mp_en one-hot on the chosen macropixel for one cycle per column, with col_en one-hot stepping through columns 0, 1, 2, 3 in that order. A column with hits is followed by its output words before the next column is enabled.
- R5: Exactly one output word is produced per hit pixel. Pixels without hits produce no word, and an empty matrix produces none.
- R6: out_word is {macropixel index, column[1:0], row[1:0], timestamp}, most significant field first. The macropixel index is band*(COLS/4)+group, where group is pixel x/4 and band is pixel y/4. Row r of a column is data_in[r].
- R7: Within one macropixel, words leave in ascending position order, with position = column*4+row.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_word does not change on the next cycle.
- R9: A macropixel stops being pending when its read ends. Hits that land in a column that was already read during that read cause a new registration, with a new timestamp, after the read ends.
- R10: After reset, out_valid, mp_en and col_en are all zero.
- R11: mp_en and col_en are each at most one-hot, and one is nonzero exactly when the other is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_in | input | TSW | Current timestamp |
| mp_hit | input | NMP | Private hit line per macropixel |
| mp_en | output | NMP | Private enable line per macropixel |
| col_en | output | 4 | Shared column-enable lines |
| data_in | input | 4 | Shared data lines, one per row of the enabled column |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | MPW+4+TSW | Formatted hit word |

## Verification
The bench builds the block as a 12-column by 8-row matrix with a 6-bit timestamp. That gives six macropixels in two bands, so the index is not a power of two and the matrix is not square, and random masks can easily select any mix of them, including the highest index. The matrix model in the bench holds the latches and clears them on read. Hits are injected in two waves with different timestamps while the output is stalled, which checks first-timestamp retention, non-preemption and re-registration. Random out_ready backpressure exercises the stall hold.

// File: rtl/mp_sparse_readout.sv
module mp_sparse_readout #(
  parameter int COLS = 32,
  parameter int ROWS = 128,
  parameter int TSW  = 8,
  localparam int MCOLS = COLS / 4,
  localparam int NMP   = MCOLS * (ROWS / 4),
  localparam int MPW   = (NMP > 1) ? $clog2(NMP) : 1,
  localparam int WW    = MPW + 4 + TSW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TSW-1:0]  ts_in,
  input  logic [NMP-1:0]  mp_hit,
  output logic [NMP-1:0]  mp_en,
  output logic [3:0]      col_en,
  input  logic [3:0]      data_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WW-1:0]   out_word
);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_EMIT} st_t;

  st_t                      st;
  logic [NMP-1:0]           pend;
  logic [NMP-1:0][TSW-1:0]  ts_q;
  logic [MPW-1:0]           cur, pick;
  logic [1:0]               col, row;
  logic [3:0]               bits, bits_nx;
  logic                     done;

  always_comb begin
    pick = '0;
    for (int i = NMP - 1; i >= 0; i--)
      if (pend[i]) pick = MPW'(i);
  end

  always_comb begin
    row = '0;
    for (int i = 3; i >= 0; i--)
      if (bits[i]) row = 2'(i);
  end

  assign bits_nx = bits & (bits - 4'd1);
  assign done = (col == 2'd3) &&
                ((st == S_CAP && data_in == 4'd0) ||
                 (st == S_EMIT && out_ready && bits_nx == 4'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ts_q <= '0;
    end else begin
      for (int k = 0; k < NMP; k++) begin
        if (done && cur == MPW'(k)) pend[k] <= 1'b0;
        else if (mp_hit[k] && !pend[k]) begin
          pend[k] <= 1'b1;
          ts_q[k] <= ts_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      col  <= '0;
      bits <= '0;
    end else begin
      case (st)
        S_IDLE: if (|pend) begin
          cur <= pick;
          col <= '0;
          st  <= S_CAP;
        end
        S_CAP: begin
          bits <= data_in;
          if (data_in != 4'd0) st <= S_EMIT;
          else if (col == 2'd3) st <= S_IDLE;
          else col <= col + 2'd1;
        end
        S_EMIT: if (out_ready) begin
          bits <= bits_nx;
          if (bits_nx == 4'd0) begin
            if (col == 2'd3) st <= S_IDLE;
            else begin
              col <= col + 2'd1;
              st  <= S_CAP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mp_en     = (st == S_CAP) ? (NMP'(1) << cur) : '0;
  assign col_en    = (st == S_CAP) ? (4'd1 << col) : 4'd0;
  assign out_valid = (st == S_EMIT);
  assign out_word  = {cur, col, row, ts_q[cur]};

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R11
  en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mp_en) && $onehot0(col_en) && ((|mp_en) == (|col_en)));

  // R3
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && |pend) |=>
      ($past(pend) & ((NMP'(1) << cur) - NMP'(1))) == '0);

  generate
    for (genvar k = 0; k < NMP; k++) begin : g_chk
      // R1
      reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mp_hit[k] && !pend[k] |=> pend[k] && ts_q[k] == $past(ts_in));
      // R2
      ts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[k] |=> !pend[k] || $stable(ts_q[k]));
    end
  endgenerate

endmodule

// File: tb/mp_sparse_readout_bench.sv
module mp_sparse_readout_bench;
  localparam int COLS = 12, ROWS = 8, TSW = 6;
  localparam int MCOLS = COLS / 4;
  localparam int NMP = MCOLS * (ROWS / 4);
  localparam int MPW = $clog2(NMP);
  localparam int WW = MPW + 4 + TSW;
  localparam int NPIX = COLS * ROWS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TSW-1:0] ts_in = '0;
  logic [NMP-1:0] mp_hit, mp_en;
  logic [3:0] col_en, data_in;
  logic out_valid, out_word_dummy;
  logic out_ready = 1'b0;
  logic [WW-1:0] out_word;
  logic [NPIX-1:0] lat, inj = '0, clr;

  always #4 clk = ~clk;

  mp_sparse_readout #(.COLS(COLS), .ROWS(ROWS), .TSW(TSW)) u_mp_sparse_readout (
    .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .mp_hit(mp_hit), .mp_en(mp_en),
    .col_en(col_en), .data_in(data_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word));

  assign out_word_dummy = 1'b0;

  function automatic int pix(int k, int c, int r);
    return ((k / MCOLS) * 4 + r) * COLS + (k % MCOLS) * 4 + c;
  endfunction

  function automatic logic [NPIX-1:0] pixvec(int k, logic [15:0] b);
    logic [NPIX-1:0] v = '0;
    for (int p = 0; p < 16; p++) if (b[p]) v[pix(k, p / 4, p % 4)] = 1'b1;
    return v;
  endfunction

  always_comb begin
    clr = '0; data_in = '0; mp_hit = '0;
    for (int k = 0; k < NMP; k++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) begin
          if (lat[pix(k, c, r)]) mp_hit[k] = 1'b1;
          if (mp_en[k] && col_en[c]) begin
            clr[pix(k, c, r)] = 1'b1;
            data_in[r] = data_in[r] | lat[pix(k, c, r)];
          end
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else lat <= (lat & ~clr) | inj;
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [WW-1:0] got [0:511];
  int got_n = 0;
  logic [NMP-1:0] log_mp [0:511];
  logic [3:0] log_col [0:511];
  int log_n = 0, en_bad = 0;
  bit rdy_rand = 0, rdy_force = 0;
  bit prev_stall = 0;
  logic [WW-1:0] prev_word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_word == prev_word, "R8", "stalled word held", out_word, prev_word);
      if (mp_en != 0 && log_n < 512) begin
        log_mp[log_n] = mp_en; log_col[log_n] = col_en; log_n++;
      end
      if (!$onehot0(mp_en) || !$onehot0(col_en) || ((|mp_en) != (|col_en))) en_bad++;
    end
    out_ready = rdy_rand ? (($urandom % 4) != 0) : rdy_force;
    if (rst_n && out_valid && out_ready && got_n < 512) begin
      got[got_n] = out_word; got_n++;
    end
    prev_stall = rst_n && out_valid && !out_ready;
    prev_word = out_word;
  end

  logic [15:0] exp_bits [NMP];
  logic [TSW-1:0] exp_ts [NMP];
  logic [WW-1:0] ew [0:255];
  int ew_n;

  task automatic add_mp(int k);
    for (int p = 0; p < 16; p++)
      if (exp_bits[k][p]) begin
        ew[ew_n] = {MPW'(k), 4'(p), exp_ts[k]}; ew_n++;
      end
  endtask

  task automatic inject(logic [NPIX-1:0] v);
    @(negedge clk); inj = v;
    @(negedge clk); inj = '0;
  endtask

  task automatic drain(int base, int expn);
    int cnt = 0;
    while (got_n - base < expn && cnt < 800) begin @(negedge clk); cnt++; end
    repeat (30) @(negedge clk);
  endtask

  task automatic compare(int base, string req);
    chk(got_n - base == ew_n, "R5", {req, " word count"}, got_n - base, ew_n);
    for (int i = 0; i < ew_n; i++)
      if (base + i < got_n)
        chk(got[base + i] == ew[i], "R6", {req, " word"}, got[base + i], ew[i]);
  endtask

  task automatic batch();
    logic [NMP-1:0] m1;
    logic [TSW-1:0] ta, tb;
    logic [NPIX-1:0] v;
    int m0, base;
    m1 = NMP'($urandom);
    if (m1 == 0) m1 = NMP'(1) << ($urandom % NMP);
    ta = TSW'($urandom); tb = ta + TSW'(17);
    m0 = -1;
    for (int k = NMP - 1; k >= 0; k--) if (m1[k]) m0 = k;
    base = got_n;
    rdy_force = 0;
    @(negedge clk); ts_in = ta;
    v = '0;
    for (int k = 0; k < NMP; k++) begin
      exp_bits[k] = '0; exp_ts[k] = ta;
      if (m1[k]) begin
        exp_bits[k] = 16'($urandom) | 16'h0001;
        v |= pixvec(k, exp_bits[k]);
      end
    end
    inject(v);
    repeat (6) @(negedge clk);
    // R3: stalled on the lowest macropixel of wave one
    chk(out_valid && out_word[WW-1 -: MPW] == MPW'(m0), "R3", "first served", out_word[WW-1 -: MPW], m0);
    ts_in = tb;
    v = '0;
    for (int k = 0; k < NMP; k++) begin
      logic [15:0] b2;
      int r = $urandom % 3;
      if (m1[k]) b2 = (r != 0) ? (16'($urandom) & 16'hFFF0) : 16'h0;
      else b2 = (r == 0) ? 16'($urandom) : 16'h0;
      if (!m1[k] && b2 != 0) exp_ts[k] = tb;
      exp_bits[k] |= b2;
      v |= pixvec(k, b2);
    end
    inject(v);
    repeat (3) @(negedge clk);
    ew_n = 0;
    add_mp(m0);
    for (int k = 0; k < NMP; k++) if (k != m0) add_mp(k);
    rdy_rand = 1;
    drain(base, ew_n);
    rdy_rand = 0;
    // R1 R2 R3 R5 R6 R7 checked together
    compare(base, "R2 batch");
  endtask

  initial begin
    int base, lb;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R10
    chk(!out_valid, "R10", "reset out_valid", out_valid, 0);
    chk(mp_en == 0, "R10", "reset mp_en", mp_en, 0);
    chk(col_en == 0, "R10", "reset col_en", col_en, 0);
    rst_n = 1'b1;

    // R5: empty matrix gives nothing
    base = got_n; lb = log_n; rdy_force = 1;
    repeat (20) @(negedge clk);
    chk(got_n == base, "R5", "empty matrix words", got_n - base, 0);
    chk(log_n == lb, "R11", "no enable when idle", log_n - lb, 0);

    // R4 R7: full highest macropixel
    base = got_n; lb = log_n; ts_in = 6'h2A;
    for (int k = 0; k < NMP; k++) begin exp_bits[k] = '0; exp_ts[k] = 6'h2A; end
    exp_bits[NMP - 1] = 16'hFFFF;
    inject(pixvec(NMP - 1, 16'hFFFF));
    ew_n = 0; add_mp(NMP - 1);
    drain(base, ew_n);
    compare(base, "R7 full");
    chk(log_n - lb == 4, "R4", "column cycles", log_n - lb, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_mp[lb + i] == (NMP'(1) << (NMP - 1)), "R4", "mp_en", log_mp[lb + i], NMP'(1) << (NMP - 1));
      chk(log_col[lb + i] == (4'd1 << i), "R4", "col_en order", log_col[lb + i], 4'd1 << i);
    end

    // R9: hit in an already read column re-registers with the new timestamp
    base = got_n; rdy_force = 0; ts_in = 6'h05;
    inject(pixvec(2, 16'h0001));
    repeat (5) @(negedge clk);
    ts_in = 6'h33;
    inject(pixvec(2, 16'h0002));
    repeat (2) @(negedge clk);
    rdy_force = 1;
    ew_n = 0;
    ew[0] = {MPW'(2), 4'd0, 6'h05};
    ew[1] = {MPW'(2), 4'd1, 6'h33};
    ew_n = 2;
    drain(base, 2);
    compare(base, "R9 reread");

    for (int b = 0; b < 10; b++) batch();

    // R11
    chk(en_bad == 0, "R11", "enable exclusivity", en_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule